// File: doc/BRIEF.md
# Interrupt Controller Base Mode Guard

This block owns the mode and address portion of an interrupt controller's base register. Software writes a full 32-bit base value through a single write strobe. The block decides whether the write is legal given the current mode and a capability input that says whether the extended addressing mode exists. It then either commits the write or rejects it with a one-cycle error pulse.

The controller has three operating modes: off, legacy, and extended. A committed write always replaces the page-aligned base address. The enable and extended flags move the mode only along the permitted paths. A write that turns the controller off raises a one-cycle pulse, which the register file uses to drop the software-enable bit of its spurious-vector register. On the one transition that enters extended mode, the block derives a cluster-style logical ID from the processor's initial ID and holds it.

All outputs are registered. A write presented in one cycle shows its effect on the outputs after the next rising clock edge.

Top module: `basemode_top`

## Requirements
- R1: After reset the mode is legacy (mode encoding: off = 0, legacy = 1, extended = 2). The base address equals the RESET_BASE parameter, the logical ID is zero, and both pulse outputs are low.
- R2: An accepted write replaces the base address with write bits [31:12]. Bits [9:0] have no effect. The assembled view always shows the address in [31:12], enable in bit 11, extended in bit 10, zero in bit 9, the BSP_INIT parameter in bit 8, and zero in bits [7:0].
- R3: A write with the extended flag (bit 10) set while the capability input is low is rejected, whatever the current mode.
- R4: A write with the extended flag set and the enable flag (bit 11) clear is rejected.
- R5: A write with both flags set while the mode is off is rejected. The mode never moves from off to extended in one step.
- R6: A write with enable set and extended clear while the mode is extended is rejected. The mode never moves from extended to legacy.
- R7: A rejected write leaves mode, address and logical ID unchanged. It raises the reject output for exactly one cycle. The reject and clear pulses are never high together.
- R8: An accepted write with the enable flag clear puts the mode in off and raises the clear pulse for exactly one cycle. This happens even when the mode was already off.
- R9: An accepted write with enable set and extended clear moves the mode from off to legacy.
- R10: An accepted write with both flags set moves the mode from legacy to extended. It loads the logical ID as initial-ID bits [19:4] placed at [31:16], ORed with a single one at bit position initial-ID[3:0]. A later accepted write while already extended keeps the stored logical ID.
- R11: An accepted write with both flags clear moves the mode from extended to off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Base register write strobe |
| wr_data | input | 32 | New base register value |
| ext_cap | input | 1 | High when extended mode is supported |
| init_id | input | 20 | Initial processor ID used for the logical ID |
| mode_o | output | 2 | Current mode (0 off, 1 legacy, 2 extended) |
| base_addr_o | output | 20 | Base address field (register bits [31:12]) |
| base_view_o | output | 32 | Assembled base register value |
| reject_o | output | 1 | One-cycle pulse for a rejected write |
| sw_en_clr_o | output | 1 | One-cycle pulse that clears the software-enable bit |
| lid_o | output | 32 | Logical ID captured on entry to extended mode |

## Verification
The assertions check four things on every cycle: the mode never jumps from off to extended or from extended back to legacy, a reject pulse never coincides with a change of mode or address, a clear pulse only ever appears with the mode off, and entry into extended mode needs the capability and yields a logical ID with exactly one member bit. Other behaviour needs the bench's chained scenarios: the exact address and logical-ID values, the fact that the ID is not recomputed on a second extended write, the low bits having no effect, and the repeated clear pulse when the controller is already off.

// File: rtl/basemode_pkg.sv
package basemode_pkg;

    localparam int REG_W     = 32;
    localparam int ADDR_W    = 20;
    localparam int ID_W      = 20;
    localparam int MEMBER_W  = 4;
    localparam int CLUSTER_W = ID_W - MEMBER_W;
    localparam int MEMBERS   = 1 << MEMBER_W;
    localparam int LID_W     = CLUSTER_W + MEMBERS;

    localparam int EN_BIT    = 11;
    localparam int EXT_BIT   = 10;
    localparam int BSP_BIT   = 8;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_LEGACY = 2'd1,
        MODE_EXT    = 2'd2
    } mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              en;
        logic              ext;
    } base_req_t;

    typedef struct packed {
        logic  accept;
        mode_e next_mode;
        logic  clr_sw;
        logic  enter_ext;
    } rule_out_t;

    function automatic base_req_t split_write(input logic [REG_W-1:0] d);
        base_req_t r;
        r.addr = d[REG_W-1 -: ADDR_W];
        r.en   = d[EN_BIT];
        r.ext  = d[EXT_BIT];
        return r;
    endfunction

    function automatic logic [REG_W-1:0] join_view(input logic [ADDR_W-1:0] addr,
                                                   input mode_e m,
                                                   input logic bsp);
        logic [REG_W-1:0] v;
        v                       = '0;
        v[REG_W-1 -: ADDR_W]    = addr;
        v[EN_BIT]               = (m != MODE_OFF);
        v[EXT_BIT]              = (m == MODE_EXT);
        v[BSP_BIT]              = bsp;
        return v;
    endfunction

endpackage

// File: rtl/basemode_rules.sv
module basemode_rules
    import basemode_pkg::*;
(
    input  mode_e     cur_mode,
    input  base_req_t req,
    input  logic      cap,
    output rule_out_t res
);

    logic bad_cap;
    logic bad_ext_off;
    logic bad_skip;
    logic bad_back;

    always_comb begin
        bad_cap     = req.ext && !cap;
        bad_ext_off = req.ext && !req.en;
        bad_skip    = (cur_mode == MODE_OFF) && req.en && req.ext;
        bad_back    = (cur_mode == MODE_EXT) && req.en && !req.ext;

        res.accept    = !(bad_cap || bad_ext_off || bad_skip || bad_back);
        res.next_mode = cur_mode;
        res.clr_sw    = 1'b0;
        res.enter_ext = 1'b0;

        if (!req.en) begin
            res.next_mode = MODE_OFF;
            res.clr_sw    = 1'b1;
        end else if (cur_mode == MODE_OFF) begin
            res.next_mode = MODE_LEGACY;
        end else if (cur_mode == MODE_LEGACY && req.ext) begin
            res.next_mode = MODE_EXT;
            res.enter_ext = 1'b1;
        end
    end

endmodule

// File: rtl/basemode_lid.sv
module basemode_lid
    import basemode_pkg::*;
(
    input  logic [ID_W-1:0]  id,
    output logic [LID_W-1:0] lid
);

    logic [MEMBERS-1:0] member_hot;

    for (genvar g = 0; g < MEMBERS; g++) begin : g_member
        assign member_hot[g] = (id[MEMBER_W-1:0] == MEMBER_W'(g));
    end

    assign lid = {id[ID_W-1:MEMBER_W], member_hot};

endmodule

// File: rtl/basemode_top.sv
module basemode_top
    import basemode_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_BASE = 20'hFEE00,
    parameter logic              BSP_INIT   = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              ext_cap,
    input  logic [ID_W-1:0]   init_id,
    output logic [1:0]        mode_o,
    output logic [ADDR_W-1:0] base_addr_o,
    output logic [REG_W-1:0]  base_view_o,
    output logic              reject_o,
    output logic              sw_en_clr_o,
    output logic [LID_W-1:0]  lid_o
);

    mode_e             mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LID_W-1:0]  lid_q;
    logic              reject_q;
    logic              clr_q;

    base_req_t         req;
    rule_out_t         rule;
    logic [LID_W-1:0]  lid_next;
    logic              unused_low_bits;

    assign req             = split_write(wr_data);
    assign unused_low_bits = ^wr_data[EXT_BIT-1:0];

    basemode_rules u_rules (
        .cur_mode (mode_q),
        .req      (req),
        .cap      (ext_cap),
        .res      (rule)
    );

    basemode_lid u_lid (
        .id  (init_id),
        .lid (lid_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_LEGACY;
            addr_q   <= RESET_BASE;
            lid_q    <= '0;
            reject_q <= 1'b0;
            clr_q    <= 1'b0;
        end else begin
            reject_q <= 1'b0;
            clr_q    <= 1'b0;
            if (wr_valid) begin
                if (rule.accept) begin
                    addr_q <= req.addr;
                    mode_q <= rule.next_mode;
                    clr_q  <= rule.clr_sw;
                    if (rule.enter_ext) begin
                        lid_q <= lid_next;
                    end
                end else begin
                    reject_q <= 1'b1;
                end
            end
        end
    end

    assign mode_o      = mode_q;
    assign base_addr_o = addr_q;
    assign base_view_o = join_view(addr_q, mode_q, BSP_INIT);
    assign reject_o    = reject_q;
    assign sw_en_clr_o = clr_q;
    assign lid_o       = lid_q;

endmodule

// File: rtl/basemode_chk.sv
module basemode_chk
    import basemode_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ext_cap,
    input logic [1:0]        mode_o,
    input logic [ADDR_W-1:0] base_addr_o,
    input logic              reject_o,
    input logic              sw_en_clr_o,
    input logic [LID_W-1:0]  lid_o
);

    // R5
    a_r5_no_off_to_ext: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_o) == MODE_OFF) |-> (mode_o != MODE_EXT));

    // R6
    a_r6_no_ext_to_legacy: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_o) == MODE_EXT) |-> (mode_o != MODE_LEGACY));

    // R7
    a_r7_reject_holds: assert property (@(posedge clk) disable iff (rst)
        reject_o |-> (mode_o == $past(mode_o)) && (base_addr_o == $past(base_addr_o))
                     && (lid_o == $past(lid_o)));

    // R7
    a_r7_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reject_o, sw_en_clr_o}));

    // R8
    a_r8_clr_means_off: assert property (@(posedge clk) disable iff (rst)
        sw_en_clr_o |-> (mode_o == MODE_OFF));

    // R3
    a_r3_ext_needs_cap: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_EXT && $past(mode_o) != MODE_EXT) |-> $past(ext_cap));

    // R10
    a_r10_lid_one_member: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_EXT && $past(mode_o) != MODE_EXT) |-> ($countones(lid_o[MEMBERS-1:0]) == 1));

endmodule

bind basemode_top basemode_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ext_cap     (ext_cap),
    .mode_o      (mode_o),
    .base_addr_o (base_addr_o),
    .reject_o    (reject_o),
    .sw_en_clr_o (sw_en_clr_o),
    .lid_o       (lid_o)
);

// File: tb/tb_basemode_top.sv
module tb_basemode_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_valid;
    logic [31:0] wr_data;
    logic        ext_cap;
    logic [19:0] init_id;
    logic [1:0]  mode_o;
    logic [19:0] base_addr_o;
    logic [31:0] base_view_o;
    logic        reject_o;
    logic        sw_en_clr_o;
    logic [31:0] lid_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #5 clk = ~clk;

    basemode_top dut (
        .clk         (clk),
        .rst         (rst),
        .wr_valid    (wr_valid),
        .wr_data     (wr_data),
        .ext_cap     (ext_cap),
        .init_id     (init_id),
        .mode_o      (mode_o),
        .base_addr_o (base_addr_o),
        .base_view_o (base_view_o),
        .reject_o    (reject_o),
        .sw_en_clr_o (sw_en_clr_o),
        .lid_o       (lid_o)
    );

    typedef struct packed {
        logic [31:0] data;
        logic        cap;
        logic [19:0] id;
        logic [1:0]  mode;
        logic        rej;
        logic        clr;
        logic [19:0] addr;
        logic [31:0] lid;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{32'hABCDE8FF, 1'b0, 20'h00000, 2'd1, 1'b0, 1'b0, 20'hABCDE, 32'h00000000}, // R2 legacy rewrite, low bits set
        '{32'h11111400, 1'b1, 20'h00000, 2'd1, 1'b1, 1'b0, 20'hABCDE, 32'h00000000}, // R4 ext without enable
        '{32'h22222C00, 1'b0, 20'h00000, 2'd1, 1'b1, 1'b0, 20'hABCDE, 32'h00000000}, // R3 ext without capability
        '{32'h33333C00, 1'b1, 20'h0ABC5, 2'd2, 1'b0, 1'b0, 20'h33333, 32'h0ABC0020}, // R10 legacy to extended
        '{32'h44444800, 1'b1, 20'h0ABC5, 2'd2, 1'b1, 1'b0, 20'h33333, 32'h0ABC0020}, // R6 extended back to legacy
        '{32'h55555C00, 1'b1, 20'hFFFFF, 2'd2, 1'b0, 1'b0, 20'h55555, 32'h0ABC0020}, // R10 id kept on rewrite
        '{32'h5A5A5C00, 1'b0, 20'hFFFFF, 2'd2, 1'b1, 1'b0, 20'h55555, 32'h0ABC0020}, // R3 in extended mode
        '{32'h66666000, 1'b1, 20'h00000, 2'd0, 1'b0, 1'b1, 20'h66666, 32'h0ABC0020}, // R11 R8 extended to off
        '{32'h77777C00, 1'b1, 20'h00000, 2'd0, 1'b1, 1'b0, 20'h66666, 32'h0ABC0020}, // R5 off to extended
        '{32'h88888000, 1'b1, 20'h00000, 2'd0, 1'b0, 1'b1, 20'h88888, 32'h0ABC0020}, // R8 off again
        '{32'h99999800, 1'b0, 20'h00000, 2'd1, 1'b0, 1'b0, 20'h99999, 32'h0ABC0020}, // R9 off to legacy
        '{32'hAAAAAC00, 1'b1, 20'h1234F, 2'd2, 1'b0, 1'b0, 20'hAAAAA, 32'h12348000}, // R10 second entry
        '{32'h123453FF, 1'b1, 20'h00000, 2'd0, 1'b0, 1'b1, 20'h12345, 32'h12348000}  // R11 R2 low bits ignored
    };

    function automatic logic [31:0] exp_view(input logic [1:0] m, input logic [19:0] a);
        return {a, (m != 2'd0), (m == 2'd2), 1'b0, 1'b1, 8'h00};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_reset_state(input string tag);
        chk({tag, " R1 mode"}, {30'd0, mode_o}, 32'd1);
        chk({tag, " R1 addr"}, {12'd0, base_addr_o}, 32'h000FEE00);
        chk({tag, " R1 R2 view"}, base_view_o, exp_view(2'd1, 20'hFEE00));
        chk({tag, " R1 pulses"}, {30'd0, reject_o, sw_en_clr_o}, 32'd0);
        chk({tag, " R1 lid"}, lid_o, 32'd0);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst      = 1'b1;
        wr_valid = 1'b0;
        wr_data  = '0;
        ext_cap  = 1'b0;
        init_id  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk_reset_state("reset");

        @(posedge clk);
        @(negedge clk);
        chk_reset_state("idle");

        for (int i = 0; i < NV; i++) begin
            wr_data  = VEC[i].data;
            ext_cap  = VEC[i].cap;
            init_id  = VEC[i].id;
            wr_valid = 1'b1;
            @(posedge clk);
            @(negedge clk);
            wr_valid = 1'b0;
            chk($sformatf("row%0d mode", i), {30'd0, mode_o}, {30'd0, VEC[i].mode});
            chk($sformatf("row%0d R2 addr", i), {12'd0, base_addr_o}, {12'd0, VEC[i].addr});
            chk($sformatf("row%0d R2 view", i), base_view_o, exp_view(VEC[i].mode, VEC[i].addr));
            chk($sformatf("row%0d R7 reject", i), {31'd0, reject_o}, {31'd0, VEC[i].rej});
            chk($sformatf("row%0d R8 clear", i), {31'd0, sw_en_clr_o}, {31'd0, VEC[i].clr});
            chk($sformatf("row%0d R10 lid", i), lid_o, VEC[i].lid);
            @(posedge clk);
            @(negedge clk);
            chk($sformatf("row%0d R7 R8 pulse width", i), {30'd0, reject_o, sw_en_clr_o}, 32'd0);
            chk($sformatf("row%0d R7 mode held", i), {30'd0, mode_o}, {30'd0, VEC[i].mode});
        end

        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk_reset_state("midrun");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule